// File: doc/BRIEF.md
# Timestamped Trace Capture Buffer

This block sits behind a transaction filter and keeps a history of the transactions that pass it. Each accepted record becomes one 128-bit entry in a circular store. An entry holds a valid bit, a gap (discontinuity) flag, a scaled timestamp, a command kind, a requester identifier, a class-dependent payload and an address. A host drains the history through a 64-bit register read port. Reading the metadata word pops the oldest entry and latches its address word, so the host can fetch the address word afterwards. The host reads until it sees an entry whose valid bit is clear. No separate empty flag exists.

Records enter on a valid/ready strobe. The block never stalls the filter while recording is enabled: `rec_ready` simply follows `cfg_enable`. A record offered while the store is full is accepted and lost, and the loss is recorded as a gap on the next entry that is written. While recording is disabled, `rec_ready` is low and the host may still drain the store. A free-running cycle counter supplies the timestamp, scaled down by 8 to the power of `cfg_grain`.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the store is empty. `rd_data` is zero, and both a metadata-word read and an address-word read return zero.
- R2: Metadata-word reads (`rd_sel`=0) return entries oldest first, one per read, with bit 63 (valid) set. The other fields of the metadata word are: bit 62 gap, bits 61:56 kind, bits 55:50 requester id, bits 49:18 timestamp, bits 17:16 zero and bits 15:0 payload. Read data appears on `rd_data` one cycle after `rd_en`.
- R3: An address-word read (`rd_sel`=1) returns the address word of the entry popped by the most recent metadata-word read. Repeating it returns the same value and pops nothing.
- R4: A metadata-word read with nothing stored returns all zeros (valid clear), and the following address-word read also returns zero.
- R5: The timestamp field equals the low 32 bits of the cycle count at acceptance shifted right by 3·`cfg_grain`. The count is zero in the first cycle after reset and rises by one every cycle.
- R6: Kinds 0x10–0x1F are store records. The payload is the 8-bit byte mask in bits 7:0, and the address word holds `rec_addr` divided by 8.
- R7: Kind 0x0F is a DMA record. The payload is {3'b0, `rec_dest`, `rec_len`}, and the address word holds `rec_addr` divided by 8.
- R8: All other kinds are plain records. The payload is zero, and the address word holds `rec_addr` unshifted and zero-extended.
- R9: A record offered while DEPTH entries are stored is dropped, and the store never holds more than DEPTH entries. The next entry written carries gap=1, and the entries after it carry gap=0.
- R10: When `cfg_enable` is low, `rec_ready` is low and offered records are not stored, while metadata-word reads still drain the existing entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Recording enable |
| cfg_grain | input | 2 | Timestamp granularity exponent G (units of 8^G cycles) |
| rec_valid | input | 1 | Record offered by the filter |
| rec_ready | output | 1 | Record accepted (follows cfg_enable) |
| rec_kind | input | 6 | Command kind code |
| rec_src | input | 6 | Requester identifier |
| rec_addr | input | 40 | Byte address |
| rec_mask | input | 8 | Byte mask (store records) |
| rec_dest | input | 5 | Destination identifier (DMA records) |
| rec_len | input | 8 | Length (DMA records) |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 = metadata word (pops), 1 = address word |
| rd_data | output | 64 | Read data, valid one cycle after rd_en |

## Verification
Several rules are checked on every cycle: occupancy never exceeds the depth, and a full store stays full until a pop. An empty pop yields a zero word, a non-empty pop yields a set valid bit, and address-word reads and disabled recording leave occupancy unchanged. Field contents need the bench's scenarios. These include the class-dependent payload and address scaling, timestamp scaling at each granularity, oldest-first order, the gap flag landing on exactly one entry after an overflow, and the latched address word.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int KIND_W  = 6;
  localparam int SRC_W   = 6;
  localparam int DEST_W  = 5;
  localparam int LEN_W   = 8;
  localparam int MASK_W  = 8;
  localparam int TS_W    = 32;
  localparam int PAY_W   = 16;
  localparam int WORD_W  = 64;
  localparam int GRAN_W  = 2;
  localparam int ENTRY_W = 2 * WORD_W;

  localparam logic [KIND_W-1:0] DMA_KIND = 6'h0F;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_STORE = 2'd1,
    CLS_DMA   = 2'd2
  } rec_class_e;

  // Metadata word occupies the upper half, address word the lower half.
  typedef struct packed {
    logic              valid;
    logic              gap;
    logic [KIND_W-1:0] kind;
    logic [SRC_W-1:0]  src;
    logic [TS_W-1:0]   stamp;
    logic [1:0]        pad;
    logic [PAY_W-1:0]  payload;
    logic [WORD_W-1:0] where;
  } entry_t;

  function automatic rec_class_e classify(input logic [KIND_W-1:0] k);
    if (k == DMA_KIND)          return CLS_DMA;
    else if (k[5:4] == 2'b01)   return CLS_STORE;
    else                        return CLS_PLAIN;
  endfunction
endpackage

// File: rtl/tcb_stamp.sv
module tcb_stamp
  import tcb_pkg::*;
#(
  parameter int STAMP_W = TS_W,
  parameter int G_W     = GRAN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [G_W-1:0]     grain_i,
  output logic [STAMP_W-1:0] stamp_o
);
  localparam int NSTEP = 1 << G_W;
  localparam int CNT_W = STAMP_W + 3 * (NSTEP - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // One candidate per granularity setting; the selected one drops 3*G bits.
  logic [STAMP_W-1:0] cand [NSTEP];
  for (genvar g = 0; g < NSTEP; g++) begin : g_scale
    assign cand[g] = cnt_q[3*g +: STAMP_W];
  end

  assign stamp_o = cand[grain_i];
endmodule

// File: rtl/tcb_pack.sv
module tcb_pack
  import tcb_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [DEST_W-1:0] dest_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [TS_W-1:0]   stamp_i,
  output entry_t            entry_o
);
  localparam int PAY_PAD = PAY_W - DEST_W - LEN_W;
  localparam int MSK_PAD = PAY_W - MASK_W;

  rec_class_e         cls;
  logic [ADDR_W-1:0]  addr_qw;

  assign cls     = classify(kind_i);
  assign addr_qw = addr_i >> 3;

  always_comb begin
    entry_o         = '0;
    entry_o.valid   = 1'b1;
    entry_o.gap     = 1'b0;
    entry_o.kind    = kind_i;
    entry_o.src     = src_i;
    entry_o.stamp   = stamp_i;
    case (cls)
      CLS_DMA: begin
        entry_o.payload = {{PAY_PAD{1'b0}}, dest_i, len_i};
        entry_o.where   = WORD_W'(addr_qw);
      end
      CLS_STORE: begin
        entry_o.payload = {{MSK_PAD{1'b0}}, mask_i};
        entry_o.where   = WORD_W'(addr_qw);
      end
      default: begin
        entry_o.payload = '0;
        entry_o.where   = WORD_W'(addr_i);
      end
    endcase
  end
endmodule

// File: rtl/tcb_ring.sv
module tcb_ring
  import tcb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_i,
  input  entry_t                   wr_entry_i,
  input  logic                     pop_i,
  output entry_t                   head_o,
  output logic                     empty_o,
  output logic [$clog2(DEPTH):0]   occ_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  entry_t        mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          pend_gap;
  logic          full, do_wr, do_pop;
  entry_t        stored;

  assign occ_o   = wr_ptr - rd_ptr;
  assign empty_o = (wr_ptr == rd_ptr);
  assign full    = (occ_o == PW'(DEPTH));
  assign do_wr   = wr_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr[AW-1:0]];

  always_comb begin
    stored     = wr_entry_i;
    stored.gap = pend_gap;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[AW-1:0]] <= stored;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      pend_gap <= 1'b0;
    end else begin
      if (do_wr)  wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      if (wr_i && full) pend_gap <= 1'b1;
      else if (do_wr)   pend_gap <= 1'b0;
    end
  end
endmodule

// File: rtl/tcb_rdport.sv
module tcb_rdport
  import tcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  input  entry_t            head_i,
  input  logic              empty_i,
  output logic              pop_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [ENTRY_W-1:0] head_bits;
  logic [WORD_W-1:0]  hold_q;
  logic               meta_rd;

  assign head_bits = head_i;
  assign meta_rd   = rd_en_i && !rd_sel_i;
  assign pop_o     = meta_rd && !empty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
      hold_q    <= '0;
    end else if (meta_rd) begin
      rd_data_o <= empty_i ? '0 : head_bits[ENTRY_W-1:WORD_W];
      hold_q    <= empty_i ? '0 : head_bits[WORD_W-1:0];
    end else if (rd_en_i) begin
      rd_data_o <= hold_q;
    end
  end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_grain,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [5:0]        rec_kind,
  input  logic [5:0]        rec_src,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic [7:0]        rec_mask,
  input  logic [4:0]        rec_dest,
  input  logic [7:0]        rec_len,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [63:0]       rd_data
);
  localparam int OCC_W = $clog2(DEPTH) + 1;

  logic [TS_W-1:0]  stamp;
  entry_t           fresh, head;
  logic             accept, pop, empty;
  logic [OCC_W-1:0] occ;

  assign rec_ready = cfg_enable;
  assign accept    = rec_valid && rec_ready;

  tcb_stamp #(.STAMP_W(TS_W), .G_W(GRAN_W)) u_stamp (
    .clk(clk), .rst(rst), .grain_i(cfg_grain), .stamp_o(stamp)
  );

  tcb_pack #(.ADDR_W(ADDR_W)) u_pack (
    .kind_i(rec_kind), .src_i(rec_src), .addr_i(rec_addr), .mask_i(rec_mask),
    .dest_i(rec_dest), .len_i(rec_len), .stamp_i(stamp), .entry_o(fresh)
  );

  tcb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst), .wr_i(accept), .wr_entry_i(fresh), .pop_i(pop),
    .head_o(head), .empty_o(empty), .occ_o(occ)
  );

  tcb_rdport u_rd (
    .clk(clk), .rst(rst), .rd_en_i(rd_en), .rd_sel_i(rd_sel), .head_i(head),
    .empty_i(empty), .pop_o(pop), .rd_data_o(rd_data)
  );
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
  parameter int DEPTH = 16,
  parameter int OCC_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_enable,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic             rd_en,
  input logic             rd_sel,
  input logic [63:0]      rd_data,
  input logic [OCC_W-1:0] occ,
  input logic             empty
);
  p_occ_bound_r9: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));

  p_full_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(DEPTH)) && !(rd_en && !rd_sel) |=> occ == OCC_W'(DEPTH));

  p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en && !rd_sel && empty |=> rd_data == 64'd0);

  p_valid_on_pop_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en && !rd_sel && !empty |=> rd_data[63]);

  p_hi_no_pop_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_sel && !(rec_valid && rec_ready) |=> occ == $past(occ));

  p_idle_when_off_r10: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable && !(rd_en && !rd_sel) |=> occ == $past(occ));
endmodule

bind trace_capture_buf tcb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .rec_valid(rec_valid),
  .rec_ready(rec_ready), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
  .occ(occ), .empty(empty)
);

// File: tb/sim_trace_capture_buf.sv
`timescale 1ns/1ps
module sim_trace_capture_buf;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_grain = 2'd0;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic [5:0]  rec_kind = '0;
  logic [5:0]  rec_src = '0;
  logic [39:0] rec_addr = '0;
  logic [7:0]  rec_mask = '0;
  logic [4:0]  rec_dest = '0;
  logic [7:0]  rec_len = '0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [63:0] rd_data;

  always #2 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH), .ADDR_W(40)) u0 (.*);

  longint unsigned cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int checks = 0, fails = 0;
  bit done = 0;
  logic [127:0] mq[$];
  bit           pend = 0;
  logic [63:0]  exp_hi = '0;
  logic [127:0] last_e;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [5:0] k, input logic [5:0] s,
      input logic [39:0] a, input logic [7:0] m, input logic [4:0] d,
      input logic [7:0] l, input bit gap, input longint unsigned c, input int g);
    logic [15:0] pay;
    logic [63:0] adr;
    logic [31:0] ts;
    ts = 32'((c >> (3*g)) & 64'hFFFF_FFFF);
    if (k == 6'h0F)            begin pay = {3'b0, d, l}; adr = 64'(a >> 3); end
    else if (k[5:4] == 2'b01)  begin pay = {8'h0, m};    adr = 64'(a >> 3); end
    else                       begin pay = 16'h0;         adr = 64'(a);      end
    return {1'b1, gap, k, s, ts, 2'b00, pay, adr};
  endfunction

  task automatic push(input logic [5:0] k, input logic [5:0] s, input logic [39:0] a,
      input logic [7:0] m, input logic [4:0] d, input logic [7:0] l);
    @(negedge clk);
    rec_valid = 1; rec_kind = k; rec_src = s; rec_addr = a;
    rec_mask = m; rec_dest = d; rec_len = l;
    if (cfg_enable) begin
      if (mq.size() == DEPTH) pend = 1;
      else begin
        mq.push_back(mk(k, s, a, m, d, l, pend, cyc, int'(cfg_grain)));
        pend = 0;
      end
    end
    @(negedge clk);
    rec_valid = 0;
  endtask

  task automatic read_lo(input string req);
    logic [127:0] e;
    @(negedge clk);
    rd_en = 1; rd_sel = 0;
    e = (mq.size() > 0) ? mq.pop_front() : 128'd0;
    exp_hi = e[63:0];
    last_e = e;
    @(negedge clk);
    rd_en = 0;
    chk(req, rd_data, e[127:64]);
  endtask

  task automatic read_hi(input string req);
    @(negedge clk);
    rd_en = 1; rd_sel = 1;
    @(negedge clk);
    rd_en = 0; rd_sel = 0;
    chk(req, rd_data, exp_hi);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 rd_data after reset", rd_data, 64'd0);
    read_lo("R1 meta read empty");
    read_hi("R1 addr read empty");

    // R2 R5 R6 R7 R8: one of each class at G=0
    cfg_enable = 1;
    push(6'h03, 6'd5, 40'h12_3456_789A, 8'hFF, 5'd1, 8'd2);     // plain R8
    push(6'h16, 6'd9, 40'h00_0000_1238, 8'hA5, 5'd0, 8'd0);     // store R6
    push(6'h0F, 6'd33, 40'h80_0000_0040, 8'h00, 5'd27, 8'h3C);  // dma R7
    read_lo("R8 plain meta");   read_hi("R8 plain address");
    read_lo("R6 store meta");   read_hi("R6 store address");
    chk("R6 mask payload", {48'd0, last_e[79:64]}, 64'h00A5);
    read_lo("R7 dma meta");     read_hi("R7 dma address");
    read_hi("R3 repeated address read");
    read_lo("R4 empty after drain"); read_hi("R4 address after empty");

    // R5: coarser granularity
    for (int g = 1; g < 4; g++) begin
      cfg_grain = 2'(g);
      repeat (g * 37) @(negedge clk);
      push(6'h05, 6'd1, 40'h100, 8'h0, 5'd0, 8'd0);
      read_lo("R5 scaled timestamp");
    end
    cfg_grain = 0;

    // R9: overflow drops and marks gap on next entry only
    for (int i = 0; i < DEPTH + 3; i++)
      push(6'h01, 6'(i), 40'(i * 8), 8'h0, 5'd0, 8'd0);
    for (int i = 0; i < DEPTH; i++) read_lo("R9 full contents");
    push(6'h02, 6'd7, 40'h777, 8'h0, 5'd0, 8'd0);
    push(6'h02, 6'd8, 40'h888, 8'h0, 5'd0, 8'd0);
    read_lo("R9 gap entry");
    chk("R9 gap bit set", {63'd0, last_e[126]}, 64'd1);
    read_lo("R9 following entry");
    chk("R9 gap bit clear", {63'd0, last_e[126]}, 64'd0);

    // R10: disabled recording ignores records, drain continues
    push(6'h04, 6'd2, 40'hABC, 8'h0, 5'd0, 8'd0);
    cfg_enable = 0;
    @(negedge clk);
    chk("R10 ready low", {63'd0, rec_ready}, 64'd0);
    push(6'h04, 6'd3, 40'hDEF, 8'h0, 5'd0, 8'd0);
    read_lo("R10 drain while off");
    read_lo("R10 nothing stored while off");

    // random mix: R2 R3 ordering and latching
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 4) begin
        if ($urandom % 10 == 0) cfg_enable = ~cfg_enable;
        if ($urandom % 10 == 0) cfg_grain = 2'($urandom);
        push(6'($urandom), 6'($urandom), 40'({$urandom, $urandom}),
             8'($urandom), 5'($urandom), 8'($urandom));
      end else if (op < 7) read_lo("R2 random order");
      else read_hi("R3 random address word");
    end
    cfg_enable = 0;
    while (mq.size() > 0) read_lo("R2 final drain");
    read_lo("R4 final empty");

    done = 1;
    summary();
    $finish;
  end
endmodule